// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers the eight interrupt sources of a two-channel serial controller into one status byte. It also drives a single active-low interrupt request from that byte through an eight-bit enable mask. Each channel contributes three sources: transmit space available, receive data available, and a break transition. One more bit reports that the counter has finished, and the last reports a change at the general-purpose input pins.

The status bits do not share one rule. The two FIFO flags follow their level comparisons on every clock. The break and counter flags latch an event pulse and hold it until a clear command arrives. The pin-change flag latches a synchronized edge and clears when software reads the pin-change register. The mask gates only the interrupt pin. The status byte always shows every active source.

The FIFOs, the receivers and the counter are outside this block. Their counts, levels and event pulses arrive as inputs.

Top module: `irq_status_agg`

## Requirements
- R1: While reset is asserted and after it is released, `irq_status` is 8'h00, the mask is 8'h00 and `irq_n` is 1.
- R2: `irq_n` is 0 exactly when some bit is 1 in both `irq_status` and the mask.
- R3: `irq_status` shows every active source whatever the mask holds. With the mask at zero, an active source gives a nonzero status and `irq_n` stays 1.
- R4: Bit 0 (channel A) and bit 4 (channel B) are 1 from the clock after `tx_free_x >= tx_lvl_x` holds, and 0 from the clock after it fails.
- R5: Bit 1 (channel A) and bit 5 (channel B) are 1 from the clock after `rx_fill_x >= rx_lvl_x` holds, and 0 from the clock after it fails.
- R6: Bit 2 (channel A) and bit 6 (channel B) set on the clock after a `brk_edge_x` pulse. They clear only on the clock after a command write to that channel with `cmd_x[7:4] == 4'h5`. Other command values leave the bit unchanged. A break pulse in the same cycle as the clear leaves the bit set.
- R7: Bit 3 sets on the clock after `ctr_done` and clears on the clock after `ctr_stop`. When both occur in the same cycle, the bit is set.
- R8: Each `pin_in` line passes through two synchronizing flops. Bit 7 sets two clocks after the edge that first samples a changed level on a pin whose `pin_chg_en` bit is 1. It clears on the clock after `pin_chg_rd`, and a set in the same cycle wins over the read. No change is reported during the first three clocks after reset.
- R9: A cycle with `mask_we` high loads `mask_din` into the mask, and the new value governs `irq_n` from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_free_a | input | CNT_W | Channel A transmit FIFO free locations |
| tx_lvl_a | input | CNT_W | Channel A transmit trigger level |
| rx_fill_a | input | CNT_W | Channel A receive FIFO occupancy |
| rx_lvl_a | input | CNT_W | Channel A receive trigger level |
| tx_free_b | input | CNT_W | Channel B transmit FIFO free locations |
| tx_lvl_b | input | CNT_W | Channel B transmit trigger level |
| rx_fill_b | input | CNT_W | Channel B receive FIFO occupancy |
| rx_lvl_b | input | CNT_W | Channel B receive trigger level |
| brk_edge_a | input | 1 | Channel A break start or end pulse |
| brk_edge_b | input | 1 | Channel B break start or end pulse |
| cmd_we_a | input | 1 | Channel A command write strobe |
| cmd_a | input | 8 | Channel A command byte |
| cmd_we_b | input | 1 | Channel B command write strobe |
| cmd_b | input | 8 | Channel B command byte |
| ctr_done | input | 1 | Counter ready pulse |
| ctr_stop | input | 1 | Stop-counter command pulse |
| pin_in | input | PORTS | Asynchronous general-purpose inputs |
| pin_chg_en | input | PORTS | Per-pin change interrupt enable |
| pin_chg_rd | input | 1 | Pin-change register read strobe |
| mask_we | input | 1 | Mask write strobe |
| mask_din | input | 8 | Mask write data |
| irq_status | output | 8 | Interrupt status byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Four sticky bits can see a set and a clear in the same cycle, and the result must be set. The cases are a break pulse with the 0x5 clear command, a counter-ready pulse with the stop command, and a synchronized pin edge with the pin-change read. A directed step drives the break pulse and the clear command in one cycle and expects the bit to stay set. A long stretch of dense random strobes makes the counter and pin-change collisions happen many times. Every clock, a behavioural model in the bench judges the result. It keeps a queue of pin samples and applies the set-wins rule.

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int CNT_W = 5,
  parameter int PORTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_free_a,
  input  logic [CNT_W-1:0] tx_lvl_a,
  input  logic [CNT_W-1:0] rx_fill_a,
  input  logic [CNT_W-1:0] rx_lvl_a,
  input  logic [CNT_W-1:0] tx_free_b,
  input  logic [CNT_W-1:0] tx_lvl_b,
  input  logic [CNT_W-1:0] rx_fill_b,
  input  logic [CNT_W-1:0] rx_lvl_b,
  input  logic             brk_edge_a,
  input  logic             brk_edge_b,
  input  logic             cmd_we_a,
  input  logic [7:0]       cmd_a,
  input  logic             cmd_we_b,
  input  logic [7:0]       cmd_b,
  input  logic             ctr_done,
  input  logic             ctr_stop,
  input  logic [PORTS-1:0] pin_in,
  input  logic [PORTS-1:0] pin_chg_en,
  input  logic             pin_chg_rd,
  input  logic             mask_we,
  input  logic [7:0]       mask_din,
  output logic [7:0]       irq_status,
  output logic             irq_n
);

  localparam logic [3:0] BRK_CLR = 4'h5;

  logic [7:0]       stat_q, mask_q;
  logic [PORTS-1:0] sync1_q, sync2_q, prev_q;
  logic [1:0]       warm_q;

  wire clr_brk_a = cmd_we_a && (cmd_a[7:4] == BRK_CLR);
  wire clr_brk_b = cmd_we_b && (cmd_b[7:4] == BRK_CLR);
  wire pin_set   = (warm_q == 2'd3) && |((sync2_q ^ prev_q) & pin_chg_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      warm_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q[0] <= tx_free_a >= tx_lvl_a;
      stat_q[1] <= rx_fill_a >= rx_lvl_a;
      stat_q[2] <= brk_edge_a | (stat_q[2] & ~clr_brk_a);
      stat_q[3] <= ctr_done   | (stat_q[3] & ~ctr_stop);
      stat_q[4] <= tx_free_b >= tx_lvl_b;
      stat_q[5] <= rx_fill_b >= rx_lvl_b;
      stat_q[6] <= brk_edge_b | (stat_q[6] & ~clr_brk_b);
      stat_q[7] <= pin_set    | (stat_q[7] & ~pin_chg_rd);
      if (mask_we) mask_q <= mask_din;
    end
  end

  assign irq_status = stat_q;
  assign irq_n      = ~|(stat_q & mask_q);

  assert_tx_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_status[0] == $past(tx_free_a >= tx_lvl_a));
  assert_rx_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_status[5] == $past(rx_fill_b >= rx_lvl_b));
  assert_brk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[2] && !clr_brk_a) |=> irq_status[2]);
  assert_brk_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_brk_b && !brk_edge_b) |=> !irq_status[6]);
  assert_ctr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_done |=> irq_status[3]);
  assert_pin_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_chg_rd && !pin_set) |=> !irq_status[7]);
  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_din));
  assert_quiet_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && mask_din == 8'h00) |=> irq_n);

endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
  localparam int CNT_W = 5;
  localparam int PORTS = 4;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] tx_free_a = 0, tx_lvl_a = 0, rx_fill_a = 0, rx_lvl_a = 0;
  logic [CNT_W-1:0] tx_free_b = 0, tx_lvl_b = 0, rx_fill_b = 0, rx_lvl_b = 0;
  logic brk_edge_a = 0, brk_edge_b = 0, cmd_we_a = 0, cmd_we_b = 0;
  logic [7:0] cmd_a = 0, cmd_b = 0, mask_din = 0;
  logic ctr_done = 0, ctr_stop = 0, pin_chg_rd = 0, mask_we = 0;
  logic [PORTS-1:0] pin_in = 0, pin_chg_en = 0;
  logic [7:0] irq_status;
  logic irq_n;

  irq_status_agg #(.CNT_W(CNT_W), .PORTS(PORTS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_free_a(tx_free_a), .tx_lvl_a(tx_lvl_a), .rx_fill_a(rx_fill_a), .rx_lvl_a(rx_lvl_a),
    .tx_free_b(tx_free_b), .tx_lvl_b(tx_lvl_b), .rx_fill_b(rx_fill_b), .rx_lvl_b(rx_lvl_b),
    .brk_edge_a(brk_edge_a), .brk_edge_b(brk_edge_b),
    .cmd_we_a(cmd_we_a), .cmd_a(cmd_a), .cmd_we_b(cmd_we_b), .cmd_b(cmd_b),
    .ctr_done(ctr_done), .ctr_stop(ctr_stop),
    .pin_in(pin_in), .pin_chg_en(pin_chg_en), .pin_chg_rd(pin_chg_rd),
    .mask_we(mask_we), .mask_din(mask_din),
    .irq_status(irq_status), .irq_n(irq_n));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  logic [7:0] m_stat = 0, m_mask = 0;
  logic       m_irq_n = 1;
  int         edges = 0;
  logic [PORTS-1:0] hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; edges = 0; hist.delete();
    end else begin
      logic det;
      edges++;
      det = 0;
      if (edges >= 4) det = |((hist[edges-3] ^ hist[edges-4]) & pin_chg_en);
      m_stat[0] = tx_free_a >= tx_lvl_a;
      m_stat[1] = rx_fill_a >= rx_lvl_a;
      m_stat[4] = tx_free_b >= tx_lvl_b;
      m_stat[5] = rx_fill_b >= rx_lvl_b;
      if (brk_edge_a) m_stat[2] = 1; else if (cmd_we_a && cmd_a[7:4] == 4'h5) m_stat[2] = 0;
      if (brk_edge_b) m_stat[6] = 1; else if (cmd_we_b && cmd_b[7:4] == 4'h5) m_stat[6] = 0;
      if (ctr_done) m_stat[3] = 1; else if (ctr_stop) m_stat[3] = 0;
      if (det) m_stat[7] = 1; else if (pin_chg_rd) m_stat[7] = 0;
      if (mask_we) m_mask = mask_din;
      hist.push_back(pin_in);
    end
    m_irq_n = ((m_stat & m_mask) == 0);
  end

  function automatic string bit_req(int b);
    case (b)
      0, 4: return "R4";
      1, 5: return "R5";
      2, 6: return "R6";
      3:    return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      for (int b = 0; b < 8; b++) begin
        compared++;
        if (irq_status[b] !== m_stat[b]) begin
          mismatched++;
          $display("FAIL %s status bit %0d: actual %b expected %b (cycle %0d)",
                   bit_req(b), b, irq_status[b], m_stat[b], cycles);
        end
      end
      compared++;
      if (irq_n !== m_irq_n) begin
        mismatched++;
        $display("FAIL R2 irq_n: actual %b expected %b (cycle %0d)", irq_n, m_irq_n, cycles);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    brk_edge_a = 0; brk_edge_b = 0; cmd_we_a = 0; cmd_we_b = 0;
    ctr_done = 0; ctr_stop = 0; pin_chg_rd = 0; mask_we = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    check(irq_status == 8'h00, "R1 status in reset", irq_status, 8'h00);
    check(irq_n == 1'b1, "R1 irq_n in reset", {7'b0, irq_n}, 8'h01);
    // hold every level flag low: free/fill below nonzero levels
    tx_lvl_a = 4; tx_lvl_b = 4; rx_lvl_a = 6; rx_lvl_b = 6;
    rst_n = 1;
    step();
    check(irq_status == 8'h00, "R1 status after reset", irq_status, 8'h00);
    check(irq_n == 1'b1, "R1 irq_n after reset", {7'b0, irq_n}, 8'h01);

    // R4 boundaries
    tx_free_a = 4; step();
    check(irq_status[0] == 1, "R4 free equals level", irq_status, 8'h01);
    tx_free_a = 3; step();
    check(irq_status[0] == 0, "R4 free below level", irq_status, 8'h00);
    // R5 boundaries
    rx_fill_b = 6; step();
    check(irq_status[5] == 1, "R5 fill equals level", irq_status, 8'h20);
    rx_fill_b = 5; step();
    check(irq_status[5] == 0, "R5 fill below level", irq_status, 8'h00);

    // R3 mask zero, status still visible
    ctr_done = 1; step(); quiet();
    check(irq_status[3] == 1, "R3/R7 counter visible", irq_status, 8'h08);
    check(irq_n == 1, "R3 masked pin idle", {7'b0, irq_n}, 8'h01);
    // R9 mask load
    mask_we = 1; mask_din = 8'h08; step(); quiet();
    check(irq_n == 0, "R9/R2 mask enables pin", {7'b0, irq_n}, 8'h00);
    ctr_done = 1; ctr_stop = 1; step(); quiet();
    check(irq_status[3] == 1, "R7 set wins over stop", irq_status, 8'h08);
    ctr_stop = 1; step(); quiet();
    check(irq_status[3] == 0 && irq_n == 1, "R7 stop clears", irq_status, 8'h00);

    // R6 break behaviour
    brk_edge_a = 1; step(); quiet();
    check(irq_status[2] == 1, "R6 break sets", irq_status, 8'h04);
    cmd_we_a = 1; cmd_a = 8'h47; step(); quiet();
    check(irq_status[2] == 1, "R6 other command ignored", irq_status, 8'h04);
    cmd_we_b = 1; cmd_b = 8'h50; step(); quiet();
    check(irq_status[2] == 1, "R6 other channel ignored", irq_status, 8'h04);
    brk_edge_a = 1; cmd_we_a = 1; cmd_a = 8'h5A; step(); quiet();
    check(irq_status[2] == 1, "R6 break wins over clear", irq_status, 8'h04);
    cmd_we_a = 1; cmd_a = 8'h53; step(); quiet();
    check(irq_status[2] == 0, "R6 clear command", irq_status, 8'h00);

    // R8 pin change
    pin_chg_en = 4'b0010; pin_in = 4'b0001; repeat (4) step();
    check(irq_status[7] == 0, "R8 disabled pin ignored", irq_status, 8'h00);
    pin_in = 4'b0011; step(); step();
    check(irq_status[7] == 0, "R8 not yet through sync", irq_status, 8'h00);
    step();
    check(irq_status[7] == 1, "R8 enabled pin sets", irq_status, 8'h80);
    pin_chg_rd = 1; step(); quiet();
    check(irq_status[7] == 0, "R8 read clears", irq_status, 8'h00);

    // random stretch, judged by the per-clock model
    for (int i = 0; i < 4000; i++) begin
      tx_free_a = CNT_W'($urandom_range(0, 16)); tx_free_b = CNT_W'($urandom_range(0, 16));
      rx_fill_a = CNT_W'($urandom_range(0, 16)); rx_fill_b = CNT_W'($urandom_range(0, 16));
      if ($urandom_range(0, 31) == 0) begin
        tx_lvl_a = CNT_W'($urandom_range(0, 16)); rx_lvl_b = CNT_W'($urandom_range(0, 16));
      end
      brk_edge_a = ($urandom_range(0, 11) == 0); brk_edge_b = ($urandom_range(0, 11) == 0);
      cmd_we_a = ($urandom_range(0, 5) == 0);
      cmd_a = $urandom_range(0, 1) ? {4'h5, 4'($urandom)} : 8'($urandom);
      cmd_we_b = ($urandom_range(0, 5) == 0);
      cmd_b = $urandom_range(0, 1) ? {4'h5, 4'($urandom)} : 8'($urandom);
      ctr_done = ($urandom_range(0, 7) == 0); ctr_stop = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 5) == 0) pin_in = pin_in ^ PORTS'(1 << $urandom_range(0, PORTS-1));
      if ($urandom_range(0, 63) == 0) pin_chg_en = PORTS'($urandom);
      pin_chg_rd = ($urandom_range(0, 6) == 0);
      mask_we = ($urandom_range(0, 19) == 0); mask_din = 8'($urandom);
      step();
    end
    quiet();
    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule